// File: doc/BRIEF.md
# Fused Redundant Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands every cycle and adds the product into a 40-bit running sum. The multiply and the add share one reduction. The partial products of the new product and the fed-back accumulator vectors are compressed together by trees of 3:2 carry-save cells. There is no separate product stage, and no carry ripples anywhere inside the feedback loop.

The reduction is split into two independent lanes. Each lane folds roughly half of the partial-product rows together with its own fed-back sum/carry pair. The two lane outputs are never merged. The accumulator state is therefore two carry-save pairs, four vectors in all, and their sum modulo 2^40 is the true total.

A read path outside the loop adds the four vectors with an ordinary adder. It registers the binary result, so the result appears one cycle after the state changes. Software-free use is simple: pulse the clear input to start a new dot product, then hold the valid input high while operands stream in.

Top module: `redundant_mac`

## Requirements
- R1: While reset is low and on the first clock after it is released, `acc_out` reads 0.
- R2: Operands are two's-complement signed. Clear together with valid makes the sum equal to the sign-extended product op_a*op_b exactly, including -32768 and 32767 on either side.
- R3: With valid high and clear low, each cycle adds op_a*op_b to the previous sum. The recursive sum over thousands of cycles matches a signed integer model modulo 2^40.
- R4: With valid and clear both low, the sum keeps its value whatever the operand inputs do.
- R5: Clear with valid low sets the sum to 0.
- R6: The sum wraps modulo 2^40 when repeated products pass the 40-bit range.
- R7: `acc_out` shows the sum as it stood after the previous clock edge, which is one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Restart the sum |
| vld_in | input | 1 | Operands valid this cycle |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| acc_out | output | 40 | Binary accumulated result |

## Verification
The checker assumes that clear and valid are plain, known levels sampled at each rising edge. It also assumes that the operands are only meaningful when valid is high, so its product check looks only at cycles where clear and valid are both high. The stimulus changes inputs only on falling edges and never leaves clear or valid unknown after reset. It drives random operands during hold cycles, so that the assertion on stable state and the bench's hold checks see real activity on the ignored inputs.

// File: rtl/mac_pkg.sv
package mac_pkg;
   localparam int unsigned DEF_OP_W  = 16;
   localparam int unsigned DEF_ACC_W = 40;
   localparam int unsigned LANES     = 2;

   function automatic int unsigned csa_next_count(input int unsigned n);
      return 2 * (n / 3) + (n % 3);
   endfunction
endpackage

// File: rtl/mac_ppgen.sv
module mac_ppgen #(
   parameter int unsigned OP_W  = 16,
   parameter int unsigned ACC_W = 40,
   localparam int unsigned ROWS = OP_W + 1
) (
   input  logic [OP_W-1:0]  mcand,
   input  logic [OP_W-1:0]  mplier,
   output logic [ACC_W-1:0] rows [ROWS]
);
   logic [ACC_W-1:0] mcand_ext;

   initial begin
      if (OP_W < 2) $error("mac_ppgen: OP_W must be at least 2");
      if (ACC_W < 2 * OP_W) $error("mac_ppgen: ACC_W too narrow");
   end

   assign mcand_ext = {{(ACC_W-OP_W){mcand[OP_W-1]}}, mcand};

   genvar i;
   generate
      for (i = 0; i < OP_W - 1; i++) begin : g_pos_row
         assign rows[i] = mplier[i] ? (mcand_ext << i) : '0;
      end
   endgenerate

   // sign bit of the multiplier weighs -2^(OP_W-1): add ~x and a +1 row
   assign rows[OP_W-1] = mplier[OP_W-1] ? ~(mcand_ext << (OP_W-1)) : '0;
   assign rows[OP_W]   = {{(ACC_W-1){1'b0}}, mplier[OP_W-1]};
endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
   parameter int unsigned W = 40,
   parameter int unsigned N = 3
) (
   input  logic [W-1:0] in_v [N],
   output logic [W-1:0] sum_v,
   output logic [W-1:0] cry_v
);
   initial begin
      if (N < 1) $error("csa_tree: N must be at least 1");
   end

   generate
      if (N == 1) begin : g_one
         assign sum_v = in_v[0];
         assign cry_v = '0;
      end else if (N == 2) begin : g_two
         assign sum_v = in_v[0];
         assign cry_v = in_v[1];
      end else begin : g_level
         localparam int unsigned TRI = N / 3;
         localparam int unsigned REM = N % 3;
         localparam int unsigned NN  = mac_pkg::csa_next_count(N);
         logic [W-1:0] nxt [NN];

         genvar t, r;
         for (t = 0; t < TRI; t++) begin : g_cell
            logic [W-1:0] x, y, z;
            assign x = in_v[3*t];
            assign y = in_v[3*t+1];
            assign z = in_v[3*t+2];
            assign nxt[2*t]   = x ^ y ^ z;
            assign nxt[2*t+1] = ((x & y) | (x & z) | (y & z)) << 1;
         end
         for (r = 0; r < REM; r++) begin : g_pass
            assign nxt[2*TRI+r] = in_v[3*TRI+r];
         end

         csa_tree #(.W(W), .N(NN)) u_sub (
            .in_v (nxt),
            .sum_v(sum_v),
            .cry_v(cry_v)
         );
      end
   endgenerate
endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned NV    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] vecs [NV],
   output logic [ACC_W-1:0] result
);
   logic [ACC_W-1:0] total;

   always_comb begin
      total = '0;
      for (int k = 0; k < NV; k++) total = total + vecs[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) result <= '0;
      else        result <= total;
   end
endmodule

// File: rtl/redundant_mac.sv
module redundant_mac #(
   parameter int unsigned OP_W  = mac_pkg::DEF_OP_W,
   parameter int unsigned ACC_W = mac_pkg::DEF_ACC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             vld_in,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   output logic [ACC_W-1:0] acc_out
);
   localparam int unsigned LANES   = mac_pkg::LANES;
   localparam int unsigned ROWS    = OP_W + 1;
   localparam int unsigned L0_ROWS = (ROWS + 1) / 2;
   localparam int unsigned L1_ROWS = ROWS - L0_ROWS;

   initial begin
      if (OP_W < 2) $error("redundant_mac: OP_W must be at least 2");
      if (ACC_W < 2 * OP_W) $error("redundant_mac: ACC_W below product width");
      if (L1_ROWS < 1) $error("redundant_mac: not enough rows to split");
   end

   logic [ACC_W-1:0] pp      [ROWS];
   logic [ACC_W-1:0] st_s    [LANES];
   logic [ACC_W-1:0] st_c    [LANES];
   logic [ACC_W-1:0] fb_s    [LANES];
   logic [ACC_W-1:0] fb_c    [LANES];
   logic [ACC_W-1:0] nx_s    [LANES];
   logic [ACC_W-1:0] nx_c    [LANES];
   logic [ACC_W-1:0] rd_vecs [2*LANES];

   mac_ppgen #(.OP_W(OP_W), .ACC_W(ACC_W)) u_ppgen (
      .mcand (op_a),
      .mplier(op_b),
      .rows  (pp)
   );

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         localparam int unsigned LO  = (g == 0) ? 0 : L0_ROWS;
         localparam int unsigned CNT = (g == 0) ? L0_ROWS : L1_ROWS;
         logic [ACC_W-1:0] ops [CNT+2];

         assign fb_s[g] = clr ? '0 : st_s[g];
         assign fb_c[g] = clr ? '0 : st_c[g];

         for (genvar k = 0; k < CNT; k++) begin : g_row
            assign ops[k] = pp[LO+k];
         end
         assign ops[CNT]   = fb_s[g];
         assign ops[CNT+1] = fb_c[g];

         csa_tree #(.W(ACC_W), .N(CNT+2)) u_tree (
            .in_v (ops),
            .sum_v(nx_s[g]),
            .cry_v(nx_c[g])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_s[g] <= '0;
               st_c[g] <= '0;
            end else if (vld_in) begin
               st_s[g] <= nx_s[g];
               st_c[g] <= nx_c[g];
            end else if (clr) begin
               st_s[g] <= '0;
               st_c[g] <= '0;
            end
         end

         assign rd_vecs[2*g]   = st_s[g];
         assign rd_vecs[2*g+1] = st_c[g];
      end
   endgenerate

   mac_readout #(.ACC_W(ACC_W), .NV(2*LANES)) u_read (
      .clk   (clk),
      .rst_n (rst_n),
      .vecs  (rd_vecs),
      .result(acc_out)
   );
endmodule

// File: rtl/redundant_mac_chk.sv
module redundant_mac_chk #(
   parameter int unsigned OP_W  = 16,
   parameter int unsigned ACC_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             vld_in,
   input logic [OP_W-1:0]  op_a,
   input logic [OP_W-1:0]  op_b,
   input logic [ACC_W-1:0] acc_out,
   input logic [ACC_W-1:0] s0,
   input logic [ACC_W-1:0] c0,
   input logic [ACC_W-1:0] s1,
   input logic [ACC_W-1:0] c1
);
   logic [ACC_W-1:0]  st_total;
   logic [2*OP_W-1:0] prod;
   logic [ACC_W-1:0]  prod_ext;

   assign st_total = s0 + c0 + s1 + c1;
   assign prod     = $signed(op_a) * $signed(op_b);
   assign prod_ext = {{(ACC_W-2*OP_W){prod[2*OP_W-1]}}, prod};

   // R1
   rst_zero_chk: assert property (@(posedge clk) !rst_n |=> acc_out == '0);

   // R2
   load_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && vld_in) |=> st_total == $past(prod_ext));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !vld_in) |=> ($stable(s0) && $stable(c0) && $stable(s1) && $stable(c1)));

   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !vld_in) |=> (s0 == '0 && c0 == '0 && s1 == '0 && c1 == '0));

   // R7
   read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> acc_out == $past(st_total));
endmodule

bind redundant_mac redundant_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .clr    (clr),
   .vld_in (vld_in),
   .op_a   (op_a),
   .op_b   (op_b),
   .acc_out(acc_out),
   .s0     (st_s[0]),
   .c0     (st_c[0]),
   .s1     (st_s[1]),
   .c1     (st_c[1])
);

// File: tb/test_redundant_mac.sv
`timescale 1ns/1ps
module test_redundant_mac;
   localparam int OP_W  = 16;
   localparam int ACC_W = 40;
   localparam longint MASK = (64'sd1 <<< ACC_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic vld_in = 1'b0;
   logic [OP_W-1:0] op_a = '0;
   logic [OP_W-1:0] op_b = '0;
   logic [ACC_W-1:0] acc_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   longint model = 0;

   always #4 clk = ~clk;

   redundant_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) i_redundant_mac (
      .clk(clk), .rst_n(rst_n), .clr(clr), .vld_in(vld_in),
      .op_a(op_a), .op_b(op_b), .acc_out(acc_out)
   );

   task automatic check(input string req, input logic [ACC_W-1:0] exp_v);
      total++;
      if (acc_out !== exp_v) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, acc_out, exp_v);
      end
   endtask

   // one clock: drive at falling edge, update model at rising edge,
   // then compare the output (which trails the state by one cycle) (R7)
   task automatic step(input logic c, input logic v, input logic [OP_W-1:0] a,
                       input logic [OP_W-1:0] b, input string req);
      longint prev;
      @(negedge clk);
      clr = c; vld_in = v; op_a = a; op_b = b;
      prev = model;
      @(posedge clk);
      if (v) model = (c ? 64'sd0 : model) + longint'($signed(a)) * longint'($signed(b));
      else if (c) model = 0;
      #2;
      check(req, ACC_W'(prev & MASK));
   endtask

   initial begin
      #1_600_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #2 check("R1 in reset", '0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #2 check("R1 after release", '0);

      // R2: single products, extremes
      step(1, 1, 16'h8000, 16'h8000, "R2 min*min");
      step(1, 1, 16'h8000, 16'h7FFF, "R2 min*max");
      step(1, 1, 16'h7FFF, 16'h7FFF, "R2 max*max");
      step(1, 1, 16'hFFFF, 16'h0003, "R2 -1*3");
      step(1, 1, 16'h0000, 16'h8000, "R2 0*min");
      step(1, 1, 16'h7FFF, 16'h8000, "R2 max*min");

      // R7: latency visible after a lone product
      step(1, 1, 16'd100, 16'd7, "R7 load");
      step(0, 0, 16'd0, 16'd0, "R7 one cycle later");
      step(0, 0, 16'd0, 16'd0, "R7 settled");

      // R3: random recursive accumulation
      for (int n = 0; n < 3000; n++)
         step(0, 1, 16'($urandom), 16'($urandom), "R3 accumulate");

      // R4: hold with toggling operands
      for (int n = 0; n < 50; n++)
         step(0, 0, 16'($urandom), 16'($urandom), "R4 hold");

      // R5: clear alone
      step(1, 0, 16'h1234, 16'h4321, "R5 clear");
      step(0, 0, 16'h5555, 16'hAAAA, "R5 cleared");
      step(0, 0, 16'h5555, 16'hAAAA, "R5 stays zero");

      // R6: wrap with runs of most negative operands
      for (int n = 0; n < 2500; n++)
         step(0, 1, 16'h8000, 16'h8000, "R6 wrap positive");
      for (int n = 0; n < 1500; n++)
         step(0, 1, 16'h8000, 16'h7FFF, "R6 wrap negative");

      // R3: mixed random with clears and gaps
      for (int n = 0; n < 2000; n++) begin
         int r = int'($urandom_range(0, 19));
         step(r == 0, r != 1, 16'($urandom), 16'($urandom), "R3 mixed");
      end
      step(0, 0, 16'd0, 16'd0, "R7 drain");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule